// File: doc/BRIEF.md
# Timing-Speculative Stage Register with Late-Sample Correction

This block is one pipeline register for a datapath that runs with reduced timing margin. A word is taken into the primary register on the rising clock edge. The same input is sampled a second time on the following falling edge. If a late-settling input changed between the two samples, the block treats the later sample as the true value. It raises a one-cycle error pulse and writes the late value over the primary register. The word then goes forward one cycle late. For that one cycle the block holds back its valid output and tells the upstream stage to stall.

A saturating error counter with a synchronous clear is provided. An external supply or clock controller can read it to judge how often margins are being violated. The register width and the counter width are parameters. A difference in any single bit counts as an error.

Top module: `spec_stage_reg`

## Requirements
- R1: With `in_stall` low, a rising edge where `in_valid` is high loads `in_data` into the primary register. If the late sample agrees, `out_data` shows that word and `out_valid` is high for exactly the next cycle, with `err_flag` low.
- R2: The late sample is taken from `in_data` at the falling edge that follows a load. Input changes after that falling edge do not affect the stage result.
- R3: When the late sample differs from the primary value in one bit or in many bits, `in_stall` is high and `out_valid` is low from that falling edge until the next rising edge.
- R4: Each detected difference produces an `err_flag` pulse that is high for exactly the one cycle after the rising edge that ends the mismatch cycle.
- R5: In the cycle where `err_flag` is high, `out_valid` is high and `out_data` equals the late sample.
- R6: A word presented with `in_valid` high on a rising edge while `in_stall` is high is not loaded and produces no output.
- R7: `err_count` increments by one for each detected difference. It stays at 2^CNT_W-1 once it reaches that value.
- R8: `err_clr` high on a rising edge sets `err_count` to zero on that edge. This takes priority over an increment on the same edge.
- R9: While `rst_n` is low, `out_valid`, `err_flag` and `in_stall` are low and `err_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; primary sample on rising edge, late sample on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word present |
| in_data | input | WIDTH | Upstream word |
| in_stall | output | 1 | Upstream must hold; no word is taken on the next rising edge |
| out_valid | output | 1 | `out_data` carries a checked word this cycle |
| out_data | output | WIDTH | Stage result, corrected when needed |
| err_flag | output | 1 | One-cycle pulse per detected timing error |
| err_clr | input | 1 | Synchronous clear of the error counter |
| err_count | output | CNT_W | Saturating count of detected errors |

## Verification
A primary register that keeps its early value instead of the restored one shows the stale word on `out_data` in the cycle after the mismatch. A lost or extra capture flag shows within one cycle as a missing, repeated or unexpected `out_valid` pulse against the queued expectations. Faults in the shadow enable or in the comparator show as a wrong `err_flag`, a wrong `in_stall`, or a drift in `err_count` compared with the number of late-changing words driven.

// File: rtl/spec_pkg.sv
package spec_pkg;

  // Saturating increment used by the error counter.
  function automatic logic [31:0] sat_step(input logic [31:0] val,
                                           input logic [31:0] top);
    return (val >= top) ? top : val + 32'd1;
  endfunction

endpackage

// File: rtl/spec_primary.sv
// Rising-edge primary register with load and restore paths.
module spec_primary #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             restore_en,
  input  logic [WIDTH-1:0] restore_val,
  output logic [WIDTH-1:0] q,
  output logic             fresh,
  output logic             recov
);
  logic [WIDTH-1:0] q_d;
  logic             fresh_d;
  logic             recov_d;

  always_comb begin
    q_d     = q;
    fresh_d = load_en;
    recov_d = restore_en;
    if (restore_en)   q_d = restore_val;
    else if (load_en) q_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      fresh <= 1'b0;
      recov <= 1'b0;
    end else begin
      q     <= q_d;
      fresh <= fresh_d;
      recov <= recov_d;
    end
  end
endmodule

// File: rtl/spec_shadow.sv
// Falling-edge late sample, taken only after a fresh primary load.
module spec_shadow #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (sample_en) q_d = d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/spec_compare.sv
// Per-bit difference detector; any differing bit is a mismatch.
module spec_compare #(
  parameter int WIDTH = 16
) (
  input  logic             check_en,
  input  logic [WIDTH-1:0] early,
  input  logic [WIDTH-1:0] late,
  output logic             mismatch
);
  logic [WIDTH-1:0] bit_diff;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_diff[i] = early[i] ^ late[i];
  end

  assign mismatch = check_en && (|bit_diff);
endmodule

// File: rtl/spec_errcnt.sv
// Registered error pulse and saturating error counter.
module spec_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic             flag,
  output logic [CNT_W-1:0] count
);
  import spec_pkg::*;

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             flag_d;
  logic [CNT_W-1:0] count_d;
  logic [31:0]      stepped;

  always_comb begin
    stepped = sat_step(32'(count), 32'(CMAX));
    flag_d  = hit;
    count_d = count;
    if (clr)      count_d = '0;
    else if (hit) count_d = stepped[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      count <= '0;
    end else begin
      flag  <= flag_d;
      count <= count_d;
    end
  end
endmodule

// File: rtl/spec_stage_reg.sv
module spec_stage_reg #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_stall,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             err_flag,
  input  logic             err_clr,
  output logic [CNT_W-1:0] err_count
);
  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] shadow_q;
  logic             fresh;
  logic             recov;
  logic             mism;
  logic             accept;

  assign accept = in_valid && !mism;

  spec_primary #(.WIDTH(WIDTH)) u_primary (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (accept),
    .load_val    (in_data),
    .restore_en  (mism),
    .restore_val (shadow_q),
    .q           (main_q),
    .fresh       (fresh),
    .recov       (recov)
  );

  spec_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (fresh),
    .d         (in_data),
    .q         (shadow_q)
  );

  spec_compare #(.WIDTH(WIDTH)) u_compare (
    .check_en (fresh),
    .early    (main_q),
    .late     (shadow_q),
    .mismatch (mism)
  );

  spec_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (mism),
    .clr   (err_clr),
    .flag  (err_flag),
    .count (err_count)
  );

  assign in_stall  = mism;
  assign out_valid = (fresh && !mism) || recov;
  assign out_data  = main_q;
endmodule

// File: rtl/spec_stage_chk.sv
module spec_stage_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_stall,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic [WIDTH-1:0] shadow_q,
  input logic             err_flag,
  input logic             err_clr,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r3_stall_hides_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> !out_valid);

  a_r4_flag_follows_stall: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |=> err_flag);

  a_r4_flag_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !err_flag);

  a_r5_restored_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |=> (out_valid && out_data == $past(shadow_q)));

  a_r7_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX && !err_clr) |=> err_count == CMAX);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err_count == '0);
endmodule

bind spec_stage_reg spec_stage_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/spec_stage_reg_bench.sv
module spec_stage_reg_bench;
  localparam int WIDTH = 16;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [WIDTH-1:0] in_data;
  logic             in_stall;
  logic             out_valid;
  logic [WIDTH-1:0] out_data;
  logic             err_flag;
  logic             err_clr;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int errors = 0;
  int n_err  = 0;
  logic [WIDTH:0] expq[$];

  spec_stage_reg #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_spec_stage_reg (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Driver: early value before the rising edge, late value after it (R2).
  task automatic send(input logic [WIDTH-1:0] early, input logic [WIDTH-1:0] late,
                      input bit hold_junk);
    @(negedge clk); #1;
    in_valid = 1'b1; in_data = early;
    @(posedge clk); #2;
    in_data = late;
    @(negedge clk); #1;
    if (early != late) n_err++;
    expq.push_back({early != late, late});
    if (hold_junk) begin
      // R6: offer a word across the stalled edge
      in_data = ~late;
      @(posedge clk); #1;
      check(in_stall == 1'b0, "R6 stall drops after edge", in_stall, 0);
      in_valid = 1'b0;
    end else begin
      in_valid = 1'b0; in_data = ~late;  // R2: change after falling edge is ignored
    end
  endtask

  // Monitor/scoreboard: sample just before each rising edge.
  initial begin
    forever begin
      @(posedge clk); #9;
      if (rst_n) begin
        if (in_stall) check(!out_valid, "R3 no valid while stalled", out_valid, 0);
        if (out_valid) begin
          if (expq.size() == 0) begin
            check(1'b0, "R6 unexpected output word", out_data, 0);
          end else begin
            logic [WIDTH:0] e;
            e = expq.pop_front();
            check(out_data == e[WIDTH-1:0], "R1/R5 output word", out_data, e[WIDTH-1:0]);
            check(err_flag == e[WIDTH], "R4 error flag with word", err_flag, e[WIDTH]);
          end
        end else begin
          check(!err_flag, "R4 flag only with restored word", err_flag, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; err_clr = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check(!out_valid && !err_flag && !in_stall, "R9 reset outputs", {out_valid, err_flag, in_stall}, 0);
    check(err_count == 0, "R9 reset count", err_count, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 clean words
    send(16'h1234, 16'h1234, 0);
    send(16'hFFFF, 16'hFFFF, 0);
    send(16'h0000, 16'h0000, 0);
    // R3/R5 single-bit and multi-bit late changes
    send(16'hA5A5, 16'hA5A4, 0);
    send(16'h00F0, 16'hF00F, 0);
    send(16'h8000, 16'h0000, 0);
    // R6 junk offered during stall
    send(16'h1111, 16'h2222, 1);
    send(16'h5A5A, 16'h5A5A, 0);
    repeat (3) @(posedge clk); #1;
    check(expq.size() == 0, "R1 all words delivered", expq.size(), 0);
    check(err_count == CNT_W'(n_err), "R7 count matches errors", err_count, n_err);

    // R8 clear on the same edge as an error
    @(negedge clk); #1;
    in_valid = 1'b1; in_data = 16'h0F0F;
    @(posedge clk); #2; in_data = 16'h0F00;
    @(negedge clk); #1; in_valid = 1'b0; err_clr = 1'b1;
    expq.push_back({1'b1, 16'h0F00});
    @(posedge clk); #1; err_clr = 1'b0;
    check(err_count == 0, "R8 clear beats increment", err_count, 0);

    // R7 saturation
    for (int i = 0; i < 9; i++) send(16'(i * 3 + 1), 16'(i * 3 + 2), 0);
    repeat (3) @(posedge clk); #1;
    check(err_count == CMAX, "R7 saturated count", err_count, CMAX);
    send(16'h7777, 16'h7770, 0);
    repeat (3) @(posedge clk); #1;
    check(err_count == CMAX, "R7 holds at max", err_count, CMAX);
    @(negedge clk); #1; err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
    check(err_count == 0, "R8 clear from max", err_count, 0);
    check(expq.size() == 0, "R6 no extra words", expq.size(), 0);
    finish_run();
  end
endmodule